// File: doc/BRIEF.md
# Signed Multi-Operand Carry-Save Adder

This block takes a parameterised number of two's complement operands, all the same width and all sharing one binary point. It returns their exact sum in a result that is wide enough never to overflow. The path is purely combinational, and the sum follows the operands with no clock involved.

Sign extension is never replicated across the result width. The sign bit of every operand is inverted and keeps its ordinary positive column weight. The column corrections that this inversion creates are merged at elaboration into one constant row. That row is the two's complement of the operand count times the weight of the sign column. The operand rows and the constant row pass through a chain of 3:2 carry-save stages until only two rows remain. A ripple carry-propagate adder then forms the final sum, and any carry out of the top column is discarded.

Operand i sits in bits [i*OP_W +: OP_W] of the flat input bus. The block is intended for dot-product and accumulation datapaths, where several signed terms must collapse into one wider word before any rounding.

Top module: `msa_signed_adder`

## Requirements
- R1: For every input pattern, `sum_o` read as a two's complement number equals the exact arithmetic sum of all operands, where each operand is read as a signed OP_W-bit value.
- R2: The width of `sum_o` is OP_W + ceil(log2(N_OPS)). This is 6 bits for 3 operands of 4 bits and 19 bits for 8 operands of 16 bits.
- R3: When every operand holds its most negative value (only bit OP_W-1 set), `sum_o` equals -N_OPS * 2^(OP_W-1) exactly. When every operand holds its most positive value, `sum_o` equals N_OPS * (2^(OP_W-1) - 1).
- R4: When every operand has bit OP_W-1 clear, bit SUM_W-1 of `sum_o` is 0. When every operand has bit OP_W-1 set, bit SUM_W-1 of `sum_o` is 1.
- R5: `sum_o` is a combinational function of `ops_i`. A new operand vector is reflected in the output within the same cycle, and the previous vector leaves no trace.
- R6: Operand i is taken from bits [i*OP_W +: OP_W] of `ops_i`. A value placed in one slot with all other slots zero produces that value, sign-extended, on `sum_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_i | input | N_OPS*OP_W | Packed signed operands, operand i in bits [i*OP_W +: OP_W] |
| sum_o | output | OP_W+ceil(log2(N_OPS)) | Two's complement sum of all operands |

## Verification
Every time the operands change, the bound checker compares the output against a plain sign-extended reference sum. It also checks that the two redundant rows left by the carry-save chain add, modulo the result width, to the output. On top of this it enforces the result sign for all-positive and all-negative operand sets, and the exact value when every operand is most negative. The bench covers what a per-cycle property cannot. It reads the result width, confirms the slot positions one operand at a time, and steps through back-to-back vectors so that no earlier input leaks into a later result. It also sweeps every combination of three 4-bit operands and checks random and corner-weighted vectors on an 8-by-16-bit instance.

// File: rtl/msa_pkg.sv
package msa_pkg;

  // Result width that holds any sum of n signed k-bit values exactly.
  function automatic int unsigned sum_width(input int unsigned n, input int unsigned k);
    return k + $clog2(n);
  endfunction

  // Bitwise sum output of a full adder.
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // Bitwise carry (majority) output of a full adder.
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/msa_operand_prep.sv
// Turns one signed operand into an unsigned row of the result width:
// the sign bit is inverted, keeps positive weight, upper columns are zero.
module msa_operand_prep #(
  parameter int unsigned OP_W  = 4,
  parameter int unsigned SUM_W = 6
) (
  input  logic [OP_W-1:0]  op_i,
  output logic [SUM_W-1:0] row_o
);
  localparam int unsigned PAD_W = SUM_W - OP_W;

  assign row_o = {{PAD_W{1'b0}}, ~op_i[OP_W-1], op_i[OP_W-2:0]};
endmodule

// File: rtl/msa_csa_row.sv
// One 3:2 carry-save stage across the full result width.
// The carry out of the top column is outside the result and is dropped.
module msa_csa_row #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-2:0] maj;

  for (genvar b = 0; b < W; b++) begin : g_sum
    assign sum_o[b] = msa_pkg::fa_sum(a_i[b], b_i[b], c_i[b]);
  end

  for (genvar b = 0; b < W - 1; b++) begin : g_maj
    assign maj[b] = msa_pkg::fa_carry(a_i[b], b_i[b], c_i[b]);
  end

  assign carry_o = {maj, 1'b0};
endmodule

// File: rtl/msa_cpa.sv
// Ripple carry-propagate adder modulo 2^W (top carry never formed).
module msa_cpa #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] cin;

  assign cin[0] = 1'b0;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign sum_o[b] = msa_pkg::fa_sum(a_i[b], b_i[b], cin[b]);
    if (b < W - 1) begin : g_prop
      assign cin[b+1] = msa_pkg::fa_carry(a_i[b], b_i[b], cin[b]);
    end
  end
endmodule

// File: rtl/msa_signed_adder.sv
// Signed multi-operand adder: inverted sign bits, one constant correction
// row, a linear carry-save chain and a final carry-propagate adder.
module msa_signed_adder #(
  parameter int unsigned N_OPS = 3,
  parameter int unsigned OP_W  = 4,
  localparam int unsigned SUM_W = msa_pkg::sum_width(N_OPS, OP_W)
) (
  input  logic [N_OPS*OP_W-1:0] ops_i,
  output logic [SUM_W-1:0]      sum_o
);
  localparam int unsigned N_ROWS   = N_OPS + 1;
  localparam int unsigned N_STAGES = N_ROWS - 2;

  // Net weight of all sign-bit corrections, as a positive magnitude.
  localparam logic [SUM_W-1:0] SIGN_BIAS = SUM_W'(N_OPS) << (OP_W - 1);
  // Constant row: two's complement of the merged bias.
  localparam logic [SUM_W-1:0] CORR_ROW  = SUM_W'(~SIGN_BIAS + SUM_W'(1));

  logic [SUM_W-1:0] rows [N_ROWS];

  for (genvar i = 0; i < N_OPS; i++) begin : g_prep
    msa_operand_prep #(.OP_W(OP_W), .SUM_W(SUM_W)) prep_i (
      .op_i (ops_i[i*OP_W +: OP_W]),
      .row_o(rows[i])
    );
  end

  assign rows[N_OPS] = CORR_ROW;

  // Redundant accumulator along the carry-save chain.
  logic [SUM_W-1:0] acc_s [N_STAGES+1];
  logic [SUM_W-1:0] acc_c [N_STAGES+1];

  assign acc_s[0] = rows[0];
  assign acc_c[0] = rows[1];

  for (genvar g = 0; g < N_STAGES; g++) begin : g_csa
    msa_csa_row #(.W(SUM_W)) csa_i (
      .a_i    (acc_s[g]),
      .b_i    (acc_c[g]),
      .c_i    (rows[g+2]),
      .sum_o  (acc_s[g+1]),
      .carry_o(acc_c[g+1])
    );
  end

  // Final two-row form, brought out by name for the checker.
  logic [SUM_W-1:0] redund_sum;
  logic [SUM_W-1:0] redund_carry;

  assign redund_sum   = acc_s[N_STAGES];
  assign redund_carry = acc_c[N_STAGES];

  msa_cpa #(.W(SUM_W)) cpa_i (
    .a_i  (redund_sum),
    .b_i  (redund_carry),
    .sum_o(sum_o)
  );
endmodule

// File: rtl/msa_signed_adder_chk.sv
module msa_signed_adder_chk #(
  parameter int unsigned N_OPS = 3,
  parameter int unsigned OP_W  = 4,
  localparam int unsigned SUM_W = msa_pkg::sum_width(N_OPS, OP_W)
) (
  input logic [N_OPS*OP_W-1:0] ops_i,
  input logic [SUM_W-1:0]      sum_o,
  input logic [SUM_W-1:0]      redund_sum,
  input logic [SUM_W-1:0]      redund_carry
);
  localparam int unsigned PAD_W = SUM_W - OP_W;
  localparam logic [SUM_W-1:0] MOST_NEG_SUM =
    SUM_W'(SUM_W'(0) - (SUM_W'(N_OPS) << (OP_W - 1)));

  logic [SUM_W-1:0] ref_sum;
  logic             all_pos;
  logic             all_neg;
  logic             all_min;

  always_comb begin
    ref_sum = '0;
    all_pos = 1'b1;
    all_neg = 1'b1;
    all_min = 1'b1;
    for (int i = 0; i < N_OPS; i++) begin
      ref_sum = ref_sum + {{PAD_W{ops_i[i*OP_W+OP_W-1]}}, ops_i[i*OP_W +: OP_W]};
      all_pos = all_pos & ~ops_i[i*OP_W+OP_W-1];
      all_neg = all_neg &  ops_i[i*OP_W+OP_W-1];
      all_min = all_min & (ops_i[i*OP_W +: OP_W] == {1'b1, {(OP_W-1){1'b0}}});
    end

    p_exact_sum_r1: assert (sum_o == ref_sum);
    // R1: the carry-save pair resolves to the output modulo 2^SUM_W
    p_redundant_pair_r1: assert (SUM_W'(redund_sum + redund_carry) == sum_o);
    p_nonneg_sign_r4: assert (!all_pos || !sum_o[SUM_W-1]);
    p_neg_sign_r4: assert (!all_neg || sum_o[SUM_W-1]);
    p_most_negative_r3: assert (!all_min || (sum_o == MOST_NEG_SUM));
  end
endmodule

bind msa_signed_adder msa_signed_adder_chk #(.N_OPS(N_OPS), .OP_W(OP_W)) chk_i (
  .ops_i       (ops_i),
  .sum_o       (sum_o),
  .redund_sum  (redund_sum),
  .redund_carry(redund_carry)
);

// File: tb/msa_signed_adder_tb_top.sv
module msa_signed_adder_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam int SM_N = 3;
  localparam int SM_K = 4;
  localparam int SM_W = 6;
  localparam int WD_N = 8;
  localparam int WD_K = 16;
  localparam int WD_W = 19;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [SM_N*SM_K-1:0] sm_ops = '0;
  logic [SM_W-1:0]      sm_sum;
  logic [WD_N*WD_K-1:0] wd_ops = '0;
  logic [WD_W-1:0]      wd_sum;

  int checks = 0;
  int fails  = 0;

  msa_signed_adder #(.N_OPS(SM_N), .OP_W(SM_K)) dut_i (
    .ops_i(sm_ops), .sum_o(sm_sum)
  );
  msa_signed_adder #(.N_OPS(WD_N), .OP_W(WD_K)) dut_wide_i (
    .ops_i(wd_ops), .sum_o(wd_sum)
  );

  function automatic longint sm_ref(input logic [SM_N*SM_K-1:0] v);
    longint acc = 0;
    for (int i = 0; i < SM_N; i++) begin
      logic signed [SM_K-1:0] f;
      f = v[i*SM_K +: SM_K];
      acc += longint'(f);
    end
    return acc;
  endfunction

  function automatic longint wd_ref(input logic [WD_N*WD_K-1:0] v);
    longint acc = 0;
    for (int i = 0; i < WD_N; i++) begin
      logic signed [WD_K-1:0] f;
      f = v[i*WD_K +: WD_K];
      acc += longint'(f);
    end
    return acc;
  endfunction

  function automatic longint sm_out();
    return longint'($signed(sm_sum));
  endfunction

  function automatic longint wd_out();
    return longint'($signed(wd_sum));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [SM_N*SM_K-1:0] s, input logic [WD_N*WD_K-1:0] w);
    @(posedge clk);
    sm_ops <= s;
    wd_ops <= w;
    @(negedge clk);
  endtask

  function automatic logic [WD_K-1:0] pick_word();
    case ($urandom_range(0, 5))
      0: return {1'b1, {(WD_K-1){1'b0}}};
      1: return {1'b0, {(WD_K-1){1'b1}}};
      2: return '0;
      3: return '1;
      default: return WD_K'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [WD_N*WD_K-1:0] w;
    void'($urandom(32'h0c5a_11ed));

    // Idle state: zero operands give a zero sum (R1)
    @(negedge clk);
    chk("R1 zero idle small", sm_out(), 0);
    chk("R1 zero idle wide", wd_out(), 0);

    // R2: result widths
    chk("R2 small width", $bits(sm_sum), SM_W);
    chk("R2 wide width", $bits(wd_sum), WD_W);

    // R3: all most negative / all most positive
    drive({SM_N{4'h8}}, {WD_N{16'h8000}});
    chk("R3 small all min", sm_out(), -24);
    chk("R3 wide all min", wd_out(), -262144);
    drive({SM_N{4'h7}}, {WD_N{16'h7fff}});
    chk("R3 small all max", sm_out(), 21);
    chk("R3 wide all max", wd_out(), 262136);

    // R4: sign of result for same-signed operand sets
    drive({4'h7, 4'h0, 4'h5}, {WD_N{16'h4000}});
    chk("R4 small nonneg sign", longint'(sm_sum[SM_W-1]), 0);
    chk("R4 wide nonneg sign", longint'(wd_sum[WD_W-1]), 0);
    drive({4'hf, 4'hf, 4'hf}, {WD_N{16'hffff}});
    chk("R4 small neg sign", longint'(sm_sum[SM_W-1]), 1);
    chk("R4 wide neg sign", longint'(wd_sum[WD_W-1]), 1);
    chk("R4 wide all minus one", wd_out(), -8);

    // R6: slot positions, one operand at a time
    for (int j = 0; j < WD_N; j++) begin
      w = '0;
      w[j*WD_K +: WD_K] = 16'hfffb;
      drive('0, w);
      chk("R6 wide slot", wd_out(), -5);
    end
    for (int j = 0; j < SM_N; j++) begin
      logic [SM_N*SM_K-1:0] s;
      s = '0;
      s[j*SM_K +: SM_K] = 4'h3;
      drive(s, '0);
      chk("R6 small slot", sm_out(), 3);
    end

    // R5: back-to-back vectors, no memory of the previous one
    drive({4'h8, 4'h8, 4'h8}, {WD_N{16'h8000}});
    chk("R5 first vector", sm_out(), -24);
    drive({4'h0, 4'h0, 4'h1}, {{(WD_N-1){16'h0000}}, 16'h0002});
    chk("R5 next vector small", sm_out(), 1);
    chk("R5 next vector wide", wd_out(), 2);

    // R1: exhaustive sweep of three 4-bit operands
    for (int v = 0; v < (1 << (SM_N*SM_K)); v++) begin
      drive(v[SM_N*SM_K-1:0], wd_ops);
      chk("R1 exhaustive small", sm_out(), sm_ref(sm_ops));
    end

    // R1: corner-weighted random vectors on the wide instance
    for (int t = 0; t < 2000; t++) begin
      for (int i = 0; i < WD_N; i++) w[i*WD_K +: WD_K] = pick_word();
      drive(sm_ops, w);
      chk("R1 random wide", wd_out(), wd_ref(w));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule